// File: doc/BRIEF.md
# Word-Rate to Bit-Rate Transmit Serializer

This block turns parallel words produced in a slow clock domain into a continuous single-line bit stream on a fast clock that runs at exactly J times the slow rate, with both clocks rising together once per word. Slow-domain logic presents a J-bit word on `par_word`. A holding register in the slow domain captures that word on every rising edge of `clk_word`. A load counter in the fast domain marks a fixed phase of each J-cycle frame. On the third `clk_bit` rising edge of the frame it raises a one-cycle load strobe, and the held word is copied into a separate shift register that drives `ser_out`.

The load strobe sits two fast cycles after the slow edge. This gives the slow-domain capture a full fast cycle to settle before the copy. Because the copy happens once per frame, the word being shifted cannot be disturbed by later activity on `par_word`. Words leave most significant bit first, one bit per fast edge, with the last bit of one word followed directly by the first bit of the next.

A small state machine with two states controls the output. SER_IDLE is entered on reset and keeps `ser_out` low with shifting disabled. The transition SER_IDLE to SER_RUN is taken on the first load strobe. SER_RUN holds itself on every later cycle, with shifting and output enabled. Reset returns the machine to SER_IDLE from either state. The serialization factor J is a parameter with legal values 4, 7, 8 and 10. The load position LOAD_EDGE defaults to 3.

Top module: `pstx_serializer`

## Requirements
- R1: While reset is held, and on the first two `clk_bit` edges after its release, `ser_out` is 0. The machine stays in SER_IDLE until the first load strobe.
- R2: The load counter resets synchronously with `rst`. It raises the load strobe for exactly one `clk_bit` cycle per J-cycle frame, on the third rising edge counted from the edge that coincides with a `clk_word` rising edge. The first load is therefore on the third `clk_bit` edge after reset is released.
- R3: The holding register takes `par_word` only at `clk_word` rising edges. A value that appears on `par_word` and is removed between two such edges is never transmitted.
- R4: On a load edge the shift register takes the held word. Bit `par_word[J-1]` appears on `ser_out` after the load edge, and each later `clk_bit` edge presents the next lower bit, down to bit 0.
- R5: There is no idle gap between words. The edge after bit 0 of one word is the load edge that presents bit J-1 of the next word.
- R6: Every supported factor J in {4, 7, 8, 10} gives a frame of exactly J bits, and the words are recovered intact from the stream.
- R7: Changes on `par_word` while a word is shifting never alter that word's bits. The held word is stable on the cycle before every load.
- R8: A reset asserted in mid-stream forces `ser_out` to 0 and returns the machine to SER_IDLE. After release, loading restarts on the third edge, as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Fast clock, one serial bit per rising edge |
| clk_word | input | 1 | Slow clock at 1/J of `clk_bit`, rising edges aligned |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| par_word | input | J | Parallel word from the slow domain, bit J-1 sent first |
| ser_out | output | 1 | Serial output line |

## Verification
The bound checker checks several properties on every fast cycle:
- the load strobe matches an independent phase count and never lasts two cycles;
- each load copies the held word, and the held word was stable one cycle before it;
- outside a load, the register shifts by exactly one place;
- `ser_out` stays low in SER_IDLE.

Some behaviour can only be shown by the bench's scenarios. These cover the exact bit order recovered from the line, the immunity of held and shifting words to short-lived changes on `par_word`, and the restart after a mid-stream reset. The bench runs them for all four legal factors at once, using a reference that rebuilds each word from the known load alignment.

// File: rtl/pstx_pkg.sv
package pstx_pkg;

    // Output controller states
    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_RUN  = 1'b1
    } ser_state_t;

endpackage

// File: rtl/pstx_load_ctr.sv
// Fast-domain frame counter: marks the fixed load phase in each J-cycle frame.
module pstx_load_ctr #(
    parameter int J         = 10,
    parameter int LOAD_EDGE = 3
) (
    input  logic clk_bit,
    input  logic rst,
    output logic load_en
);
    localparam int             CW       = (J > 1) ? $clog2(J) : 1;
    localparam logic [CW-1:0]  LAST     = CW'(J - 1);
    localparam logic [CW-1:0]  LOAD_IDX = CW'(LOAD_EDGE - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign load_en = (phase == LOAD_IDX);

endmodule

// File: rtl/pstx_hold_reg.sv
// Slow-domain holding register: captures the parallel word once per word clock.
module pstx_hold_reg #(
    parameter int J = 10
) (
    input  logic         clk_word,
    input  logic         rst,
    input  logic [J-1:0] d,
    output logic [J-1:0] q
);
    always_ff @(posedge clk_word) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pstx_tx_fsm.sv
// Output controller: idle until the first load, then running for good.
module pstx_tx_fsm (
    input  logic                   clk_bit,
    input  logic                   rst,
    input  logic                   load_en,
    output pstx_pkg::ser_state_t   state,
    output logic                   shift_en,
    output logic                   drive_en
);
    import pstx_pkg::*;

    ser_state_t state_nxt;

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            state <= SER_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SER_IDLE: if (load_en) state_nxt = SER_RUN;
            SER_RUN:  state_nxt = SER_RUN;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        drive_en = 1'b0;
        unique case (state)
            SER_IDLE: begin
                shift_en = 1'b0;
                drive_en = 1'b0;
            end
            SER_RUN: begin
                shift_en = 1'b1;
                drive_en = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pstx_shift_reg.sv
// Serial shift register: parallel load has priority, otherwise shift toward MSB.
module pstx_shift_reg #(
    parameter int J = 10
) (
    input  logic         clk_bit,
    input  logic         rst,
    input  logic         load_en,
    input  logic         shift_en,
    input  logic [J-1:0] par_in,
    output logic [J-1:0] q
);
    always_ff @(posedge clk_bit) begin
        if (rst) begin
            q <= '0;
        end else if (load_en) begin
            q <= par_in;
        end else if (shift_en) begin
            q <= {q[J-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/pstx_serializer.sv
// Top: word-rate to bit-rate transmit serializer.
module pstx_serializer #(
    parameter int J         = 10,
    parameter int LOAD_EDGE = 3
) (
    input  logic         clk_bit,
    input  logic         clk_word,
    input  logic         rst,
    input  logic [J-1:0] par_word,
    output logic         ser_out
);
    import pstx_pkg::*;

    logic             load_en;
    logic             shift_en;
    logic             drive_en;
    ser_state_t       state;
    logic [J-1:0]     hold_q;
    logic [J-1:0]     shift_q;

    pstx_hold_reg #(.J(J)) u_hold (
        .clk_word (clk_word),
        .rst      (rst),
        .d        (par_word),
        .q        (hold_q)
    );

    pstx_load_ctr #(.J(J), .LOAD_EDGE(LOAD_EDGE)) u_ctr (
        .clk_bit  (clk_bit),
        .rst      (rst),
        .load_en  (load_en)
    );

    pstx_tx_fsm u_fsm (
        .clk_bit  (clk_bit),
        .rst      (rst),
        .load_en  (load_en),
        .state    (state),
        .shift_en (shift_en),
        .drive_en (drive_en)
    );

    pstx_shift_reg #(.J(J)) u_shift (
        .clk_bit  (clk_bit),
        .rst      (rst),
        .load_en  (load_en),
        .shift_en (shift_en),
        .par_in   (hold_q),
        .q        (shift_q)
    );

    assign ser_out = drive_en & shift_q[J-1];

endmodule

// File: rtl/pstx_checker.sv
// Property checker, bound into every instance of the serializer.
module pstx_checker #(
    parameter int J         = 10,
    parameter int LOAD_EDGE = 3
) (
    input  logic                 clk_bit,
    input  logic                 rst,
    input  logic                 load_en,
    input  pstx_pkg::ser_state_t state,
    input  logic [J-1:0]         hold_q,
    input  logic [J-1:0]         shift_q,
    input  logic                 ser_out
);
    import pstx_pkg::*;

    // Independent phase reference for the load position
    int ph;
    always_ff @(posedge clk_bit) begin
        if (rst) begin
            ph <= 0;
        end else begin
            ph <= (ph == J - 1) ? 0 : ph + 1;
        end
    end

    // R1: the line stays low until the first word is running
    assert_idle_low_R1: assert property (@(posedge clk_bit) disable iff (rst)
        (state == SER_IDLE) |-> !ser_out);

    // R2: the strobe sits on the fixed frame phase
    assert_load_phase_R2: assert property (@(posedge clk_bit) disable iff (rst)
        load_en == (ph == LOAD_EDGE - 1));

    // R2: the strobe never lasts two cycles
    assert_single_load_R2: assert property (@(posedge clk_bit) disable iff (rst)
        load_en |=> !load_en);

    // R4: a load copies the held word
    assert_load_copy_R4: assert property (@(posedge clk_bit) disable iff (rst)
        load_en |=> (shift_q == $past(hold_q)));

    // R4: while running, the line shows the register MSB
    assert_msb_out_R4: assert property (@(posedge clk_bit) disable iff (rst)
        (state == SER_RUN) |-> (ser_out == shift_q[J-1]));

    // R5: between loads the register moves by exactly one place
    assert_shift_step_R5: assert property (@(posedge clk_bit) disable iff (rst)
        (state == SER_RUN && !load_en) |=> (shift_q == {$past(shift_q[J-2:0]), 1'b0}));

    // R7: the held word has settled before it is copied
    assert_hold_settled_R7: assert property (@(posedge clk_bit) disable iff (rst)
        load_en |-> $stable(hold_q));

endmodule

bind pstx_serializer pstx_checker #(.J(J), .LOAD_EDGE(LOAD_EDGE)) u_chk (
    .clk_bit (clk_bit),
    .rst     (rst),
    .load_en (load_en),
    .state   (state),
    .hold_q  (hold_q),
    .shift_q (shift_q),
    .ser_out (ser_out)
);

// File: tb/pstx_serializer_test.sv
`timescale 1ns/1ps
module pstx_serializer_test;

    logic clk_bit = 1'b0;
    always #10 clk_bit = ~clk_bit;   // 50 MHz

    int       checks = 0;
    int       errors = 0;
    bit [3:0] done   = '0;

    task automatic tally(input string tag, input int jf, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s J=%0d got %0d expected %0d", tag, jf, got, exp);
        end
    endtask

    for (genvar g = 0; g < 4; g++) begin : g_lane
        localparam int J  = (g == 0) ? 4 : (g == 1) ? 7 : (g == 2) ? 8 : 10;
        localparam int NF = 40;

        logic         clk_word = 1'b0;
        logic         rst      = 1'b1;
        logic [J-1:0] par_word = '0;
        logic         ser_out;
        logic [J-1:0] words [0:NF-1];
        bit           glitched [0:NF-1];
        int           lane_bad = 0;

        // word clock: rising edges coincide with clk_bit rising edges at 10 + 20*J*k
        initial begin
            #10;
            forever begin
                clk_word = 1'b1;
                #(J * 10);
                clk_word = 1'b0;
                #(J * 10);
            end
        end

        pstx_serializer #(.J(J)) uut (
            .clk_bit  (clk_bit),
            .clk_word (clk_word),
            .rst      (rst),
            .par_word (par_word),
            .ser_out  (ser_out)
        );

        task automatic lane_check(input string tag, input logic got, input logic exp);
            if (got !== exp) lane_bad++;
            tally(tag, J, int'(got), int'(exp));
        endtask

        task automatic make_words(input int nf);
            for (int f = 0; f < nf; f++) begin
                logic [31:0] r;
                r = $urandom();
                words[f]    = r[J-1:0];
                glitched[f] = 1'b0;
            end
            words[0] = '1;
            words[1] = '0;
            for (int b = 0; b < J; b++) words[2][b] = b[0];
        endtask

        // rst must be high; releases so that edge 1 is a word-clock edge
        task automatic run_stream(input int nf, input bit restart);
            par_word = words[0];
            do @(negedge clk_bit); while (($time % (20 * J)) != 0);
            rst = 1'b0;
            for (int e = 1; e <= 2 + nf * J; e++) begin
                int p;
                int fr;
                @(negedge clk_bit);
                p  = (e - 1) % J;
                fr = (e - 1) / J;
                if (fr + 1 < nf) begin
                    if (p == 0) begin
                        if (fr % 3 == 1) begin
                            par_word         = ~words[fr + 1];
                            glitched[fr + 1] = 1'b1;
                        end else begin
                            par_word = words[fr + 1];
                        end
                    end else if (p == 1) begin
                        par_word = words[fr + 1];
                    end
                end
                if (e < 3) begin
                    lane_check(restart ? "R8" : "R1", ser_out, 1'b0);
                end else begin
                    int    f;
                    int    n;
                    string tag;
                    f = (e - 3) / J;
                    n = (e - 3) % J;
                    if (e == 3)                            tag = restart ? "R8" : "R2";
                    else if (n == 0)                       tag = "R5";
                    else if (glitched[f])                  tag = "R3";
                    else if (f + 1 < nf && glitched[f+1])  tag = "R7";
                    else                                   tag = "R4";
                    lane_check(tag, ser_out, words[f][J-1-n]);
                end
            end
        endtask

        initial begin : stim
            int bad_before;
            void'($urandom(32'd1357 + g));
            repeat (2) @(negedge clk_bit);
            lane_check("R1", ser_out, 1'b0);          // reset state
            make_words(NF);
            run_stream(NF, 1'b0);
            // mid-stream reset
            rst = 1'b1;
            for (int k = 0; k < 2 * J; k++) begin
                @(negedge clk_bit);
                if (k > 0) lane_check("R8", ser_out, 1'b0);
            end
            make_words(12);
            run_stream(12, 1'b1);
            bad_before = lane_bad;
            tally("R6", J, bad_before, 0);           // all frames of this factor intact
            done[g] = 1'b1;
        end
    end

    initial begin
        fork
            wait (&done);
            begin
                repeat (150000) @(posedge clk_bit);
                errors++;
                $display("FAIL R6 watchdog expired got done=%b expected 1111", done);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule